// File: doc/BRIEF.md
# Power-of-Two Delay One-Shot

This block is a triggered one-shot timer. A trigger edge starts an output pulse, and the pulse lasts a power-of-two number of timebase ticks. A 4-bit select input picks the length. Bit 3 of the select chooses between a short range and a long range. One trigger input fires on its rising edge and the other fires on its falling edge. Tying the two inputs together makes either edge fire.

The timebase is not a second clock. It arrives as a one-cycle strobe on the system clock, and each strobe marks a falling edge of the slow time source. A pulse starts on the system clock, with no wait for a strobe. It ends only on a strobe, once the programmed count has been reached.

A mode input chooses what happens when a trigger arrives during a pulse:
- In retriggerable mode, the trigger restarts the count, so the pulse can be stretched.
- In the other mode, the trigger is ignored.

An active-high master reset and an active-low power-on reset both end a pulse at once, without waiting for a clock edge. A clock-enable output tells the timebase source when it must run, so the source can be stopped while the timer is idle.

Top module: `pow2_oneshot`

## Requirements
- R1: A rising edge on `trig_rise` starts a pulse, and a falling edge on `trig_fall` starts a pulse. A falling edge on `trig_rise` does not start a pulse, and neither does a rising edge on `trig_fall`.
- R2: While a pulse is active, `q` is 1 and `qn` is 0. When idle, `q` is 0 and `qn` is 1.
- R3: The pulse lasts exactly N timebase strobes. With `sel[3]`=0, N = 2^(`sel[2:0]`+1), which covers 2 to 256. With `sel[3]`=1, N = 2^(`sel[2:0]`+17), which covers 131072 to 16777216. The strobe that arrives in the same cycle as the start is not counted.
- R4: With `retrig_en`=1, a trigger during a pulse restarts the count from zero. The pulse then ends N strobes after the last trigger.
- R5: With `retrig_en`=0, triggers during a pulse have no effect on the pulse or on its length.
- R6: `mreset`=1 or `por_n`=0 clears the count and drops `q` immediately, without waiting for a clock edge.
- R7: `tb_enable` is 1 whenever `osc_run`=1. When `osc_run`=0, `tb_enable` is 1 only while a pulse is active.
- R8: `q` rises on the third rising clock edge after a trigger edge, whatever the strobe phase. It falls only on a clock edge where `tb_strobe` is 1.
- R9: Trigger edges that fall within the first three clock edges after reset is released are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mreset | input | 1 | Master reset, active high, asynchronous |
| trig_rise | input | 1 | Trigger input; its rising edge fires |
| trig_fall | input | 1 | Trigger input; its falling edge fires |
| retrig_en | input | 1 | 1 = a trigger during a pulse restarts the count |
| sel | input | 4 | Length select: bit 3 picks the range, bits 2:0 the power |
| osc_run | input | 1 | 1 = timebase runs at all times, 0 = only during a pulse |
| tb_strobe | input | 1 | One-cycle tick marking each timebase falling edge |
| q | output | 1 | Pulse output, active high |
| qn | output | 1 | Complement of `q` |
| tb_enable | output | 1 | Run enable for the timebase source |

## Verification
A trigger edge shows up on `q` at the third rising clock edge after it is applied. Two of those edges are the synchronizer and the third is the state register. The end of a pulse comes on the edge that carries the Nth strobe. The reset effects and `tb_enable` are combinational from state, so they are due at once.

The bench keeps a behavioural model that replays the same three-edge latency from a short history of sampled inputs. It compares `q`, `qn` and `tb_enable` one time unit after every rising edge. The directed pulse-width checks sample at falling edges, and the reset checks sample within the same half cycle, before any clock edge.

// File: rtl/pow2_oneshot.sv
module pow2_oneshot #(
  parameter int CW        = 24,
  parameter int SHORT_OFS = 1,
  parameter int LONG_OFS  = 17
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mreset,
  input  logic          trig_rise,
  input  logic          trig_fall,
  input  logic          retrig_en,
  input  logic [3:0]    sel,
  input  logic          osc_run,
  input  logic          tb_strobe,
  output logic          q,
  output logic          qn,
  output logic          tb_enable
);
  localparam int SW = $clog2(CW + 1);

  logic          rst;
  logic [2:0]    a_sh, b_sh;
  logic [1:0]    warm;
  logic          active;
  logic [CW-1:0] cnt;
  logic [SW-1:0] pow;
  logic [CW-1:0] last;
  logic          rise_ev, fall_ev, fire;

  assign rst = mreset | ~por_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      a_sh <= '0;
      b_sh <= '0;
      warm <= '0;
    end else begin
      a_sh <= {a_sh[1:0], trig_rise};
      b_sh <= {b_sh[1:0], trig_fall};
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign rise_ev = (warm == 2'd3) &  a_sh[1] & ~a_sh[2];
  assign fall_ev = (warm == 2'd3) & ~b_sh[1] &  b_sh[2];
  assign fire    = (rise_ev | fall_ev) & (~active | retrig_en);

  assign pow  = SW'(sel[2:0]) + SW'(sel[3] ? LONG_OFS : SHORT_OFS);
  assign last = {CW{1'b1}} >> (SW'(CW) - pow);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tb_strobe) begin
      if (cnt == last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign q         = active;
  assign qn        = ~active;
  assign tb_enable = osc_run | active;

  AST_NORETRIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !retrig_en && !tb_strobe) |=> (cnt == $past(cnt))); // R5
  AST_END_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(tb_strobe)); // R8
  AST_START_AFTER_WARM: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> ($past(warm) == 2'd3)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !active |-> (cnt == '0)); // R6
endmodule

// File: tb/tb_pow2_oneshot.sv
`timescale 1ns/1ps
module tb_pow2_oneshot;
  logic clk = 1'b0;
  logic por_n = 1'b0, mreset = 1'b0;
  logic trig_rise = 1'b0, trig_fall = 1'b0, retrig_en = 1'b0;
  logic [3:0] sel = 4'd0;
  logic osc_run = 1'b0, tb_strobe = 1'b0;
  logic q, qn, tb_enable;

  int checks = 0, errors = 0;
  int tb_div = 1, ph = 0, cycles = 0;
  bit done = 0;

  pow2_oneshot dut (.clk(clk), .por_n(por_n), .mreset(mreset),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .retrig_en(retrig_en),
    .sel(sel), .osc_run(osc_run), .tb_strobe(tb_strobe),
    .q(q), .qn(qn), .tb_enable(tb_enable));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    ph = (ph + 1 >= tb_div) ? 0 : ph + 1;
    tb_strobe <= (ph == 0);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference: three-edge trigger latency, strobe counting
  bit ha[$], hb[$];
  bit m_act = 0;
  longint m_cnt = 0;
  always @(posedge clk) begin
    if (!por_n || mreset) begin
      ha.delete(); hb.delete(); m_act = 0; m_cnt = 0;
    end else begin
      bit trg;
      longint n_len;
      ha.push_back(trig_rise); hb.push_back(trig_fall);
      if (ha.size() > 4) begin void'(ha.pop_front()); void'(hb.pop_front()); end
      trg = 0;
      if (ha.size() == 4) trg = (ha[1] && !ha[0]) || (!hb[1] && hb[0]);
      n_len = sel[3] ? (64'd1 << (sel[2:0] + 17)) : (64'd1 << (sel[2:0] + 1));
      if (trg && (!m_act || retrig_en)) begin m_act = 1; m_cnt = 0; end
      else if (m_act && tb_strobe) begin
        m_cnt++;
        if (m_cnt == n_len) begin m_act = 0; m_cnt = 0; end
      end
    end
    #1;
    if (!done) begin
      chk(q == m_act, "R2 model q", q, m_act);
      chk(qn == !m_act, "R2 model qn", qn, !m_act);
      chk(tb_enable == (osc_run | m_act), "R7 model tb_enable", tb_enable, osc_run | m_act);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R3 actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_pulse(input bit use_b, input int retrig_at, input int limit,
                           output int width, output int first_hi);
    int cyc;
    bit seen;
    if (use_b) begin
      trig_fall = 1;
      repeat (5) @(negedge clk);
      chk(q == 0, "R1 rising trig_fall ignored", q, 0);
      trig_fall = 0;
    end else trig_rise = 1;
    width = 0; seen = 0; cyc = 0; first_hi = -1;
    while (cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) trig_rise = 0;
      if (retrig_at > 0 && cyc == retrig_at) trig_rise = 1;
      if (retrig_at > 0 && cyc == retrig_at + 2) trig_rise = 0;
      if (q) begin
        if (!seen) first_hi = cyc;
        width++; seen = 1;
      end else if (seen) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int w, f;
    repeat (3) @(negedge clk);
    chk(q == 0 && qn == 1, "R2 reset state q", q, 0);
    chk(tb_enable == 0, "R7 idle enable off", tb_enable, 0);
    por_n = 1;
    repeat (5) @(negedge clk);

    sel = 4'd0; run_pulse(0, 0, 100, w, f);
    chk(w == 2, "R3 sel0 width", w, 2);
    chk(f == 3, "R8 start latency", f, 3);
    chk(q == 0, "R1 falling trig_rise ignored", q, 0);

    sel = 4'd3; run_pulse(1, 0, 100, w, f);
    chk(w == 16, "R1 R3 trig_fall sel3 width", w, 16);

    sel = 4'd7; run_pulse(0, 0, 400, w, f);
    chk(w == 256, "R3 sel7 width", w, 256);

    sel = 4'd4; retrig_en = 1; run_pulse(0, 20, 200, w, f);
    chk(w == 52, "R4 retrigger extends", w, 52);

    retrig_en = 0; run_pulse(0, 20, 200, w, f);
    chk(w == 32, "R5 no-retrigger width", w, 32);

    tb_div = 8; sel = 4'd0; run_pulse(0, 0, 100, w, f);
    chk(f == 3, "R8 start not waiting for strobe", f, 3);
    chk(w >= 9 && w <= 16, "R8 strobe-paced width", w, 16);
    tb_div = 1;

    sel = 4'd4; trig_rise = 1;
    repeat (6) @(negedge clk);
    chk(tb_enable == 1, "R7 enable during pulse", tb_enable, 1);
    chk(qn == 0, "R2 qn active", qn, 0);
    trig_rise = 0; mreset = 1; #1;
    chk(q == 0, "R6 mreset immediate", q, 0);
    repeat (2) @(negedge clk); mreset = 0;
    repeat (5) @(negedge clk);
    chk(q == 0, "R6 stays idle after mreset", q, 0);

    trig_rise = 1;
    repeat (6) @(negedge clk);
    trig_rise = 0; por_n = 0; #1;
    chk(q == 0, "R6 por immediate", q, 0);
    repeat (2) @(negedge clk);

    trig_rise = 1; por_n = 1;
    repeat (10) @(negedge clk);
    chk(q == 0, "R9 edge at reset release ignored", q, 0);
    trig_rise = 0;
    repeat (3) @(negedge clk);

    osc_run = 1; #1;
    chk(tb_enable == 1, "R7 run mode enable", tb_enable, 1);
    osc_run = 0;

    tb_div = 1; sel = 4'd8; run_pulse(0, 0, 140000, w, f);
    chk(w == 131072, "R3 long range sel8 width", w, 131072);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule